// File: doc/BRIEF.md
# Variable-Length Pattern Bus Encoder

This block sits on the transmit side of an off-chip data bus and reduces how often the bus lines toggle. It gathers a short run of consecutive data words, between one and four, into a pattern. Patterns tend to recur close together in time, so the block keeps a table of recently sent patterns. Each incoming pattern is looked up in that table.

When a stored pattern equals the incoming one, a single header beat replaces the data. When a stored pattern covers only the leading words, the header beat names that entry, and the words after the covered part follow as raw beats. When nothing matches, the words go out raw and the pattern is stored in the table.

Words arrive on a valid/ready stream. A marker on the stream closes each pattern. The encoded beats leave on a valid-only output, one beat per cycle. The input stalls while a pattern is being looked up and sent.

Top module: `vlp_bus_encoder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and every table entry is invalid. The first pattern sent after reset is therefore always encoded as a miss.
- R2: A pattern ends on the word accepted with `in_last` = 1, or on its fourth accepted word, whichever comes first. The next accepted word starts a new pattern.
- R3: On a miss, each word of the pattern leaves as a raw beat, in arrival order. A raw beat has `out_code` = 00, the word on `out_data`, and `out_index` = 0 and `out_mlen` = 0. The pattern is then written into the table.
- R4: When a valid entry has the same length and words as the incoming pattern, exactly one beat is sent. That beat has `out_code` = 01, the entry number on `out_index`, the pattern length minus one on `out_mlen`, and `out_data` = 0.
- R5: When the best matching entry is shorter than the pattern, a header beat is sent first. The header has `out_code` = 10, the entry number on `out_index`, the number of matched words minus one on `out_mlen`, and `out_data` = 0. The words after the matched prefix then follow as raw beats, in order. No table write takes place.
- R6: An entry matches only if it is valid, no longer than the pattern, and equal to the pattern's leading words. Among matching entries the longest one wins, and on equal length the lowest entry number wins. An entry longer than the pattern never matches it.
- R7: A miss writes its pattern into the slot named by a round-robin pointer. The pointer starts at 0, advances by one on each write only, and wraps after the last slot. The 65th miss therefore overwrites slot 0.
- R8: `in_ready` is 0 from the cycle after the closing word is accepted until the last beat of that pattern has been sent. Out of reset the code value 11 never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | WORD_W | Input data word |
| in_last | input | 1 | Accepted word closes the pattern |
| out_valid | output | 1 | Encoded beat valid |
| out_code | output | 2 | Beat type: 00 raw, 01 full match, 10 partial match |
| out_index | output | log2(DEPTH) | Table entry of a match header |
| out_mlen | output | log2(MAX_LEN) | Matched words minus one on a header |
| out_data | output | WORD_W | Raw word, zero on header beats |

## Verification
The bench builds the block with its default parameters: 32-bit words, at most four words per pattern, and a 64-entry table. With these values, 64 writes fill the table and a 65th miss wraps the replacement pointer, all well inside the cycle budget. This lets the bench confirm that partial and full matches never consumed a slot. It also checks that the overwritten entry turns back into a miss, while its neighbours still hit at their original entry numbers. The four-word limit makes the closing rule without a marker reachable, and it lets a stored two-word pattern compete against a one-word pattern when the longest prefix is chosen.

// File: rtl/vlp_bus_encoder.sv
module vlp_bus_encoder #(
  parameter int WORD_W  = 32,
  parameter int MAX_LEN = 4,
  parameter int DEPTH   = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORD_W-1:0]           in_data,
  input  logic                        in_last,
  output logic                        out_valid,
  output logic [1:0]                  out_code,
  output logic [$clog2(DEPTH)-1:0]    out_index,
  output logic [$clog2(MAX_LEN)-1:0]  out_mlen,
  output logic [WORD_W-1:0]           out_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(MAX_LEN);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [1:0] C_RAW  = 2'b00;
  localparam logic [1:0] C_FULL = 2'b01;
  localparam logic [1:0] C_PART = 2'b10;

  typedef enum logic [1:0] {S_COL, S_LOOK, S_EMIT} st_t;

  st_t                state;
  logic [LEN_W-1:0]   cnt, last_len, hit_mlen;
  logic [WORD_W-1:0]  wbuf [MAX_LEN];
  logic [1:0]         kind;
  logic [IDX_W-1:0]   hit_idx, wr_ptr, best_i;
  logic [CNT_W-1:0]   pos, best_n;
  logic               hdr, miss, full;

  logic [DEPTH-1:0]   ent_v;
  logic [LEN_W-1:0]   ent_len [DEPTH];
  logic [WORD_W-1:0]  ent_w   [DEPTH][MAX_LEN];

  always_comb begin
    best_n = '0;
    best_i = '0;
    for (int e = 0; e < DEPTH; e++) begin
      logic hit;
      hit = ent_v[e] && (ent_len[e] <= last_len);
      for (int w = 0; w < MAX_LEN; w++)
        if (w <= int'(ent_len[e]) && ent_w[e][w] != wbuf[w]) hit = 1'b0;
      if (hit && (CNT_W'(ent_len[e]) + CNT_W'(1) > best_n)) begin
        best_n = CNT_W'(ent_len[e]) + CNT_W'(1);
        best_i = IDX_W'(e);
      end
    end
  end

  assign miss = (best_n == '0);
  assign full = (best_n == CNT_W'(last_len) + CNT_W'(1));

  assign in_ready  = (state == S_COL);
  assign out_valid = (state == S_EMIT);
  assign out_code  = hdr ? kind : C_RAW;
  assign out_index = hdr ? hit_idx : '0;
  assign out_mlen  = hdr ? hit_mlen : '0;
  assign out_data  = hdr ? '0 : wbuf[pos[LEN_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_COL;
      cnt      <= '0;
      last_len <= '0;
      kind     <= C_RAW;
      hit_idx  <= '0;
      hit_mlen <= '0;
      hdr      <= 1'b0;
      pos      <= '0;
      wr_ptr   <= '0;
      ent_v    <= '0;
    end else begin
      case (state)
        S_COL: if (in_valid) begin
          if (in_last || cnt == LEN_W'(MAX_LEN - 1)) begin
            last_len <= cnt;
            cnt      <= '0;
            state    <= S_LOOK;
          end else cnt <= cnt + 1'b1;
        end
        S_LOOK: begin
          kind     <= miss ? C_RAW : (full ? C_FULL : C_PART);
          hit_idx  <= best_i;
          hit_mlen <= LEN_W'(best_n - CNT_W'(1));
          hdr      <= !miss;
          pos      <= best_n;
          if (miss) begin
            ent_v[wr_ptr] <= 1'b1;
            wr_ptr <= (wr_ptr == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
          end
          state <= S_EMIT;
        end
        S_EMIT: begin
          if (hdr) begin
            hdr <= 1'b0;
            if (pos == CNT_W'(last_len) + CNT_W'(1)) state <= S_COL;
          end else begin
            pos <= pos + 1'b1;
            if (pos == CNT_W'(last_len)) state <= S_COL;
          end
        end
        default: state <= S_COL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_COL && in_valid) wbuf[cnt] <= in_data;
    if (state == S_LOOK && miss) begin
      ent_len[wr_ptr] <= last_len;
      for (int w = 0; w < MAX_LEN; w++) ent_w[wr_ptr][w] <= wbuf[w];
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_last || cnt == LEN_W'(MAX_LEN - 1)) |=> !in_ready); // R8
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_code != 2'b11); // R8
  AST_FULL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == C_FULL |=> !out_valid); // R4
  AST_PART_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == C_PART |=> out_valid && out_code == C_RAW); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_LOOK && miss) |=> $stable(wr_ptr)); // R7
  AST_RAW_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == C_RAW |-> out_index == '0 && out_mlen == '0); // R3
endmodule

// File: tb/sim_vlp_bus_encoder.sv
module sim_vlp_bus_encoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid;
  logic [1:0] out_code;
  logic [5:0] out_index;
  logic [1:0] out_mlen;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  vlp_bus_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_code(out_code), .out_index(out_index), .out_mlen(out_mlen),
    .out_data(out_data));

  int total = 0, fails = 0;
  int cap_n = 0;
  logic [1:0]  cap_code [16];
  logic [5:0]  cap_idx  [16];
  logic [1:0]  cap_mlen [16];
  logic [31:0] cap_data [16];

  always @(negedge clk)
    if (out_valid && cap_n < 16) begin
      cap_code[cap_n] = out_code;
      cap_idx[cap_n]  = out_index;
      cap_mlen[cap_n] = out_mlen;
      cap_data[cap_n] = out_data;
      cap_n++;
    end

  // {nolast, len, w0, w1, w2, w3, code, index, mlen}
  localparam int NV = 13;
  localparam logic [141:0] VEC [NV] = '{
    {1'b0, 3'd2, 32'hA0000001, 32'hA0000002, 32'h0, 32'h0, 2'b00, 6'd0, 2'd0},
    {1'b0, 3'd2, 32'hA0000001, 32'hA0000002, 32'h0, 32'h0, 2'b01, 6'd0, 2'd1},
    {1'b0, 3'd3, 32'hA0000001, 32'hA0000002, 32'hA0000003, 32'h0, 2'b10, 6'd0, 2'd1},
    {1'b0, 3'd1, 32'hB0000001, 32'h0, 32'h0, 32'h0, 2'b00, 6'd0, 2'd0},
    {1'b0, 3'd3, 32'hB0000001, 32'hB0000002, 32'hB0000003, 32'h0, 2'b10, 6'd1, 2'd0},
    {1'b1, 3'd4, 32'hA0000001, 32'hA0000002, 32'hA0000003, 32'hA0000004, 2'b10, 6'd0, 2'd1},
    {1'b0, 3'd2, 32'hD0000001, 32'hD0000002, 32'h0, 32'h0, 2'b00, 6'd0, 2'd0},
    {1'b0, 3'd1, 32'hD0000001, 32'h0, 32'h0, 32'h0, 2'b00, 6'd0, 2'd0},
    {1'b0, 3'd3, 32'hD0000001, 32'hD0000002, 32'hD0000003, 32'h0, 2'b10, 6'd2, 2'd1},
    {1'b0, 3'd1, 32'hD0000001, 32'h0, 32'h0, 32'h0, 2'b01, 6'd3, 2'd0},
    {1'b0, 3'd2, 32'hD0000001, 32'hD0000002, 32'h0, 32'h0, 2'b01, 6'd2, 2'd1},
    {1'b0, 3'd4, 32'hF0000001, 32'hF0000002, 32'hF0000003, 32'hF0000004, 2'b00, 6'd0, 2'd0},
    {1'b0, 3'd4, 32'hF0000001, 32'hF0000002, 32'hF0000003, 32'hF0000004, 2'b01, 6'd4, 2'd3}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [31:0] w [4], input bit nolast);
    cap_n = 0;
    for (int k = 0; k < n; k++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = w[k];
      in_last  = !nolast && (k == n - 1);
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
    chk(in_ready == 1'b0, "R8", "ready after closing word", 64'(in_ready), 64'd0);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic expect_beats(input string req, input int n, input logic [31:0] w [4],
                              input logic [1:0] code, input logic [5:0] idx,
                              input logic [1:0] mlen);
    int m, nexp, b;
    m    = (code == 2'b00) ? 0 : int'(mlen) + 1;
    nexp = (code == 2'b00) ? n : 1 + (n - m);
    chk(cap_n == nexp, req, "beat count", 64'(cap_n), 64'(nexp));
    b = 0;
    if (code != 2'b00 && cap_n > 0) begin
      chk(cap_code[0] == code && cap_idx[0] == idx && cap_mlen[0] == mlen && cap_data[0] == 0,
          req, "header {code,index,mlen,data}",
          {cap_code[0], cap_idx[0], cap_mlen[0], cap_data[0]}, {code, idx, mlen, 32'h0});
      b = 1;
    end
    for (int k = m; k < n; k++) begin
      if (b < cap_n)
        chk(cap_code[b] == 2'b00 && cap_idx[b] == 0 && cap_mlen[b] == 0 && cap_data[b] == w[k],
            req, "raw beat {code,index,mlen,data}",
            {cap_code[b], cap_idx[b], cap_mlen[b], cap_data[b]}, {10'h0, w[k]});
      b++;
    end
  endtask

  task automatic run1(input string req, input logic [31:0] word,
                      input logic [1:0] code, input logic [5:0] idx);
    logic [31:0] w [4];
    w = '{word, 32'h0, 32'h0, 32'h0};
    send(1, w, 1'b0);
    expect_beats(req, 1, w, code, idx, 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset {ready,valid}",
        {62'h0, in_ready, out_valid}, 64'h2);

    for (int i = 0; i < NV; i++) begin
      logic [141:0] v;
      logic [31:0] w [4];
      string req;
      v = VEC[i];
      for (int k = 0; k < 4; k++) w[k] = v[137 - 32*k -: 32];
      if (i == 0) req = "R1";
      else if (i == 5) req = "R2";
      else if (i == 7 || i == 8) req = "R6";
      else if (v[9:8] == 2'b00) req = "R3";
      else if (v[9:8] == 2'b01) req = "R4";
      else req = "R5";
      send(int'(v[140:138]), w, v[141]);
      expect_beats(req, int'(v[140:138]), w, v[9:8], v[7:2], v[1:0]);
    end

    // R7: fill slots 5..63, then wrap to slot 0
    for (int i = 0; i < 59; i++) run1("R7", 32'h10000000 + 32'(i), 2'b00, 6'd0);
    run1("R7", 32'h20000000, 2'b00, 6'd0);
    run1("R7", 32'h20000000, 2'b01, 6'd0);
    begin
      logic [31:0] w [4];
      w = '{32'hA0000001, 32'hA0000002, 32'h0, 32'h0};
      send(2, w, 1'b0);
      expect_beats("R7", 2, w, 2'b00, 6'd0, 2'd0);
    end
    run1("R7", 32'hD0000001, 2'b01, 6'd3);
    run1("R7", 32'h10000000, 2'b01, 6'd5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule